// File: doc/BRIEF.md
# Serial Memory Slave with Hold and Status Protection

This block answers an SPI master as a small byte-addressed memory. It decodes an 8-bit command, collects a 24-bit address, and then streams bytes in or out in a burst, stepping the address after each byte. A separate status byte reports a write-enable latch and keeps six protection bits that software may set. It works with a clock that idles low (mode 0) or high (mode 3). In both modes it samples on the rising edge of the serial clock and shifts output on the falling edge.

The SPI pins are not clocked directly. Two flip-flops bring each pin into a fast system clock domain, and the block acts on the edges it detects there. The system clock must run at least four times the serial clock rate. The serial clock may stop at any point. An active-low hold pin pauses a transfer while the select line stays low, and the transfer then picks up exactly where it stopped. An active-low protect pin blocks status-byte writes and has no effect on memory writes. The output is a data bit plus a separate drive-enable, so the chip's pad logic forms the tri-state buffer.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset the drive-enable is low, the write-enable latch is clear, the status byte reads 0x00 and every memory byte reads 0x00.
- R2: While the select line is high, clock and data activity has no effect: no command runs and the drive-enable stays low.
- R3: Command 0x06 sets the write-enable latch. Command 0x04 clears it. The latch reads back as bit 1 of the status byte.
- R4: A write command (0x02) sent while the write-enable latch is clear leaves memory unchanged.
- R5: In mode 0, command 0x03 followed by a 24-bit address (MSB first) reads bytes MSB first, one after another from that address. Command 0x02 writes bytes in the same way.
- R6: Reads and writes give the same results in mode 3 as in mode 0.
- R7: Only the low log2(depth) address bits select a byte. A burst wraps from the last byte to byte 0.
- R8: The write-enable latch clears when the select line rises after a 0x02 or 0x01 command.
- R9: The drive-enable is high only during the data phase of a read (0x03) or status read (0x05). It is low during the command and address bits and after deselect.
- R10: While hold is low and the select line is low, the drive-enable is low, and clock and select changes are ignored. After hold returns high the transfer continues bit for bit.
- R11: Command 0x01 with the write-enable latch set writes status bits 7:2. Status bit 0 always reads 0. A low protect pin blocks the status write.
- R12: After an unknown command byte, all further bits are ignored until the select line rises: no latch, memory or status change, and no drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sckIn | input | 1 | Serial clock from the master |
| csN | input | 1 | Active-low select |
| siIn | input | 1 | Serial data in |
| holdN | input | 1 | Active-low pause |
| wpN | input | 1 | Active-low status-write protect |
| soOut | output | 1 | Serial data out |
| soOe | output | 1 | Drive-enable for the serial output pad |

## Verification
The assertions check on every cycle that:
- the write-enable latch rises only in the cycle after a set strobe;
- the status protection bits never move while the protect pin is low;
- the control state and bit counter stay frozen while hold is active;
- an unknown command stays in its ignore state until deselect.

Only the bench's scenarios can show the rest:
- that bursts return the right bytes in both clock modes;
- that address wrap lands on byte 0;
- that a held transfer resumes with the correct bit;
- that bus activity with the select line high leaves the device untouched.

// File: rtl/spimem_pkg.sv
package spimem_pkg;

  typedef enum logic [2:0] {
    ST_OPC, ST_ADDR, ST_RD, ST_WR, ST_RDSR, ST_WRSR, ST_SKIP
  } phase_e;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic addrShift;
    logic addrInc;
    logic memWrite;
    logic statWrite;
    logic setWel;
    logic clrWel;
    logic loadOut;
    logic shiftOut;
    logic selStatus;
    logic outEnable;
    logic siBit;
    logic wpLvl;
  } strobe_t;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRIT = 8'h02;

endpackage

// File: rtl/spimem_ctrl.sv
module spimem_ctrl
  import spimem_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sckIn,
  input  logic       csN,
  input  logic       siIn,
  input  logic       holdN,
  input  logic       wpN,
  input  logic [6:0] rxShift,
  output strobe_t    str
);

  localparam int CNT_W = $clog2(ADDR_W);
  localparam logic [4:0] PIN_IDLE = 5'b01011; // {sck, cs, si, hold, wp}

  logic [SYNC_STAGES-1:0][4:0] pinQ;
  logic [4:0] pins;
  logic sckS, csS, siS, holdS, wpS;
  logic sckPrev, csAct, holdActive, rise, fall;
  logic [7:0] rxNext;
  phase_e state;
  logic [CNT_W-1:0] bitCnt;
  logic [2:0] rdCnt;
  logic isRead, clrPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinQ <= {SYNC_STAGES{PIN_IDLE}};
    else       pinQ <= {pinQ[SYNC_STAGES-2:0], {sckIn, csN, siIn, holdN, wpN}};
  end

  assign pins = pinQ[SYNC_STAGES-1];
  assign {sckS, csS, siS, holdS, wpS} = pins;

  assign holdActive = csAct && !holdS;
  assign rise   = sckS && !sckPrev && csAct && !holdActive;
  assign fall   = !sckS && sckPrev && csAct && !holdActive;
  assign rxNext = {rxShift, siS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
      csAct   <= 1'b0;
    end else begin
      sckPrev <= sckS;
      if (!holdActive) csAct <= !csS;
    end
  end

  always_comb begin
    str           = '0;
    str.siBit     = siS;
    str.wpLvl     = wpS;
    str.selStatus = (state == ST_RDSR);
    str.outEnable = csAct && !holdActive && (state == ST_RD || state == ST_RDSR);
    if (!csAct && clrPend) str.clrWel = 1'b1;
    if (rise) begin
      case (state)
        ST_OPC: begin
          str.shiftIn = 1'b1;
          if (bitCnt == CNT_W'(7)) begin
            if (rxNext == OP_WREN) str.setWel = 1'b1;
            if (rxNext == OP_WRDI) str.clrWel = 1'b1;
          end
        end
        ST_ADDR: str.addrShift = 1'b1;
        ST_WR: begin
          str.shiftIn = 1'b1;
          if (bitCnt == CNT_W'(7)) begin
            str.memWrite = 1'b1;
            str.addrInc  = 1'b1;
          end
        end
        ST_WRSR: begin
          str.shiftIn = 1'b1;
          if (bitCnt == CNT_W'(7)) str.statWrite = 1'b1;
        end
        default: ;
      endcase
    end
    if (fall && (state == ST_RD || state == ST_RDSR)) begin
      if (rdCnt == 3'd0) str.loadOut  = 1'b1;
      else               str.shiftOut = 1'b1;
      if (rdCnt == 3'd7 && state == ST_RD) str.addrInc = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_OPC;
      bitCnt  <= '0;
      rdCnt   <= '0;
      isRead  <= 1'b0;
      clrPend <= 1'b0;
    end else if (!csAct) begin
      state   <= ST_OPC;
      bitCnt  <= '0;
      rdCnt   <= '0;
      isRead  <= 1'b0;
      clrPend <= 1'b0;
    end else if (rise) begin
      case (state)
        ST_OPC: begin
          if (bitCnt == CNT_W'(7)) begin
            bitCnt <= '0;
            rdCnt  <= '0;
            case (rxNext)
              OP_RDSR: state <= ST_RDSR;
              OP_WRSR: begin state <= ST_WRSR; clrPend <= 1'b1; end
              OP_READ: begin state <= ST_ADDR; isRead <= 1'b1; end
              OP_WRIT: begin state <= ST_ADDR; isRead <= 1'b0; clrPend <= 1'b1; end
              default: state <= ST_SKIP;
            endcase
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_ADDR: begin
          if (bitCnt == CNT_W'(ADDR_W - 1)) begin
            bitCnt <= '0;
            rdCnt  <= '0;
            state  <= isRead ? ST_RD : ST_WR;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_WR:   bitCnt <= (bitCnt == CNT_W'(7)) ? '0 : bitCnt + 1'b1;
        ST_WRSR: begin
          if (bitCnt == CNT_W'(7)) state <= ST_SKIP;
          else                     bitCnt <= bitCnt + 1'b1;
        end
        default: ;
      endcase
    end else if (fall && (state == ST_RD || state == ST_RDSR)) begin
      rdCnt <= rdCnt + 1'b1;
    end
  end

  // R10: nothing advances while a transfer is held
  a_r10_hold_freezes: assert property (@(posedge clk) disable iff (!rstN)
    (holdActive && $past(holdActive)) |-> ($stable(state) && $stable(bitCnt)));

  // R12: an unknown command stays ignored until deselect
  a_r12_skip_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP && csAct) |=> (state == ST_SKIP));

endmodule

// File: rtl/spimem_datapath.sv
module spimem_datapath
  import spimem_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    str,
  output logic [6:0] rxShift,
  output logic       soOut,
  output logic       soOe
);

  localparam int IDX_W = $clog2(DEPTH);

  logic [7:0] mem [DEPTH];
  logic [ADDR_W-1:0] addrReg;
  logic [IDX_W-1:0] idx;
  logic [7:0] rxNext, statusByte, curByte;
  logic [5:0] statBits;
  logic [6:0] outShift;
  logic wel, soBit;

  assign idx        = addrReg[IDX_W-1:0];
  assign rxNext     = {rxShift, str.siBit};
  assign statusByte = {statBits, wel, 1'b0};
  assign curByte    = str.selStatus ? statusByte : mem[idx];
  assign soOut      = soBit;
  assign soOe       = str.outEnable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel      <= 1'b0;
      statBits <= '0;
      rxShift  <= '0;
      addrReg  <= '0;
      outShift <= '0;
      soBit    <= 1'b0;
    end else begin
      if (str.clrWel)      wel <= 1'b0;
      else if (str.setWel) wel <= 1'b1;
      if (str.statWrite && wel && str.wpLvl) statBits <= rxNext[7:2];
      if (str.shiftIn) rxShift <= rxNext[6:0];
      if (str.addrShift)    addrReg <= {addrReg[ADDR_W-2:0], str.siBit};
      else if (str.addrInc) addrReg <= addrReg + 1'b1;
      if (str.loadOut) begin
        soBit    <= curByte[7];
        outShift <= curByte[6:0];
      end else if (str.shiftOut) begin
        soBit    <= outShift[6];
        outShift <= {outShift[5:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (str.memWrite && wel) begin
      mem[idx] <= rxNext;
    end
  end

  // R3: the latch only sets after an explicit set strobe
  a_r3_wel_from_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wel) |-> $past(str.setWel));

  // R11: protection bits hold while the protect pin is low
  a_r11_wp_freezes_status: assert property (@(posedge clk) disable iff (!rstN)
    !str.wpLvl |=> $stable(statBits));

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spimem_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int ADDR_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sckIn,
  input  logic csN,
  input  logic siIn,
  input  logic holdN,
  input  logic wpN,
  output logic soOut,
  output logic soOe
);

  strobe_t str;
  logic [6:0] rxShift;

  spimem_ctrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .csN(csN), .siIn(siIn),
    .holdN(holdN), .wpN(wpN), .rxShift(rxShift), .str(str)
  );

  spimem_datapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .rxShift(rxShift),
    .soOut(soOut), .soOe(soOe)
  );

endmodule

// File: tb/spi_mem_slave_tb.sv
module spi_mem_slave_tb;

  localparam int DEPTH = 16;
  localparam int HALF  = 6;

  logic clk = 1'b0, rstN = 1'b0;
  logic sckR = 1'b0, csR = 1'b1, siR = 1'b0, holdR = 1'b1, wpR = 1'b1;
  logic soOut, soOe;

  int nChk = 0, nFail = 0;
  bit mode3 = 1'b0;
  bit oeAny, oeAll;
  logic [7:0] model [DEPTH];
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];

  spi_mem_slave #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .sckIn(sckR), .csN(csR), .siIn(siR),
    .holdN(holdR), .wpN(wpR), .soOut(soOut), .soOe(soOe)
  );

  always #10 clk = ~clk;

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bitx(input logic b, output logic r);
    sckR = 1'b0;
    siR  = b;
    wt(HALF);
    r = soOut;
    oeAny |= soOe;
    oeAll &= soOe;
    sckR = 1'b1;
    wt(HALF);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    oeAny = 1'b0;
    oeAll = 1'b1;
    for (int i = 7; i >= 0; i--) bitx(tx[i], rx[i]);
  endtask

  task automatic sel();
    sckR = mode3;
    wt(HALF);
    csR = 1'b0;
    wt(HALF);
  endtask

  task automatic desel();
    if (!mode3) begin sckR = 1'b0; wt(HALF); end
    csR = 1'b1;
    wt(2 * HALF);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    sel(); xfer(op, d); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    sel(); xfer(8'h05, d);
    chk(!oeAny, "R9 no drive in status opcode", oeAny, 0);
    xfer(8'h00, s);
    chk(oeAll, "R9 drive in status data", oeAll, 1);
    desel();
  endtask

  task automatic sendAddr(input logic [23:0] a);
    logic [7:0] d;
    xfer(a[23:16], d); xfer(a[15:8], d); xfer(a[7:0], d);
  endtask

  task automatic wrMem(input logic [23:0] a, input int n, input bit welSet);
    logic [7:0] d;
    sel(); xfer(8'h02, d); sendAddr(a);
    for (int k = 0; k < n; k++) begin
      xfer(wbuf[k], d);
      if (welSet) model[(int'(a) + k) % DEPTH] = wbuf[k];
    end
    desel();
  endtask

  task automatic rdMem(input logic [23:0] a, input int n);
    logic [7:0] d;
    sel(); xfer(8'h03, d);
    chk(!oeAny, "R9 no drive in read opcode", oeAny, 0);
    sendAddr(a);
    chk(!oeAny, "R9 no drive in address", oeAny, 0);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, rbuf[k]);
      chk(oeAll, "R9 drive in read data", oeAll, 1);
    end
    desel();
    chk(soOe == 1'b0, "R9 no drive after deselect", soOe, 0);
  endtask

  task automatic fillPattern(input int base, input int n);
    for (int k = 0; k < n; k++) wbuf[k] = 8'((k * 37 + base) & 8'hFF);
  endtask

  task automatic holdRead(input logic [23:0] a);
    logic [7:0] d, b0, b1, b2;
    logic r;
    sel(); xfer(8'h03, d); sendAddr(a);
    xfer(8'h00, b0);
    for (int i = 7; i >= 4; i--) begin bitx(1'b0, r); b1[i] = r; end
    holdR = 1'b0; wt(HALF);
    chk(soOe == 1'b0, "R10 drive off in hold", soOe, 0);
    sckR = 1'b0; wt(HALF); sckR = 1'b1; wt(HALF);
    csR = 1'b1; wt(HALF);
    chk(soOe == 1'b0, "R10 drive off in hold with select high", soOe, 0);
    sckR = 1'b0; wt(HALF); sckR = 1'b1; wt(HALF);
    csR = 1'b0; wt(HALF);
    holdR = 1'b1; wt(HALF);
    for (int i = 3; i >= 0; i--) begin bitx(1'b0, r); b1[i] = r; end
    xfer(8'h00, b2);
    desel();
    chk(b0 == model[(int'(a)) % DEPTH], "R10 byte before hold", b0, model[(int'(a)) % DEPTH]);
    chk(b1 == model[(int'(a) + 1) % DEPTH], "R10 byte across hold", b1, model[(int'(a) + 1) % DEPTH]);
    chk(b2 == model[(int'(a) + 2) % DEPTH], "R10 byte after hold", b2, model[(int'(a) + 2) % DEPTH]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    nChk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    logic [7:0] s, d;
    logic r;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    wt(5);
    rstN = 1'b1;
    wt(5);

    // R1 reset state
    chk(soOe == 1'b0, "R1 drive off after reset", soOe, 0);
    rdsr(s);
    chk(s == 8'h00, "R1 status after reset", s, 8'h00);
    rdMem(24'h0, DEPTH);
    for (int k = 0; k < DEPTH; k++)
      chk(rbuf[k] == 8'h00, "R1 memory after reset", rbuf[k], 0);

    // R3 latch set and clear
    cmd1(8'h06); rdsr(s);
    chk(s[1] == 1'b1, "R3 latch set", s, 8'h02);
    cmd1(8'h04); rdsr(s);
    chk(s == 8'h00, "R3 latch cleared", s, 8'h00);

    // R4 write without latch
    fillPattern(8'h55, 1);
    wrMem(24'h5, 1, 1'b0);
    rdMem(24'h5, 1);
    chk(rbuf[0] == model[5], "R4 write ignored without latch", rbuf[0], model[5]);

    // R5 mode 0 full-array burst write then read
    cmd1(8'h06);
    fillPattern(5, DEPTH);
    wrMem(24'h0, DEPTH, 1'b1);
    rdsr(s);
    chk(s[1] == 1'b0, "R8 latch cleared after write", s, 0);
    rdMem(24'h0, DEPTH);
    for (int k = 0; k < DEPTH; k++)
      chk(rbuf[k] == model[k], "R5 mode 0 burst", rbuf[k], model[k]);

    // R6 mode 3 read and write
    mode3 = 1'b1;
    rdMem(24'h0, DEPTH);
    for (int k = 0; k < DEPTH; k++)
      chk(rbuf[k] == model[k], "R6 mode 3 read", rbuf[k], model[k]);
    cmd1(8'h06);
    fillPattern(100, 4);
    wrMem(24'h3, 4, 1'b1);
    mode3 = 1'b0;
    rdMem(24'h0, DEPTH);
    for (int k = 0; k < DEPTH; k++)
      chk(rbuf[k] == model[k], "R6 mode 3 write seen in mode 0", rbuf[k], model[k]);

    // R7 wrap with high address bits set
    cmd1(8'h06);
    fillPattern(200, 4);
    wrMem(24'h12340E, 4, 1'b1);
    rdMem(24'hABCD0E, 4);
    for (int k = 0; k < 4; k++)
      chk(rbuf[k] == model[(14 + k) % DEPTH], "R7 wrap burst", rbuf[k], model[(14 + k) % DEPTH]);
    rdMem(24'h0, DEPTH + 4);
    for (int k = 0; k < DEPTH + 4; k++)
      chk(rbuf[k] == model[k % DEPTH], "R7 read wrap", rbuf[k], model[k % DEPTH]);

    // R11 status writes and protection
    cmd1(8'h06);
    sel(); xfer(8'h01, d); xfer(8'hFF, d); desel();
    rdsr(s);
    chk(s == 8'hFC, "R11 status write, bit 0 stays 0", s, 8'hFC);
    chk(s[1] == 1'b0, "R8 latch cleared after status write", s, 0);
    wpR = 1'b0;
    cmd1(8'h06);
    sel(); xfer(8'h01, d); xfer(8'h00, d); desel();
    rdsr(s);
    chk(s == 8'hFC, "R11 protect blocks status write", s, 8'hFC);
    cmd1(8'h06);
    fillPattern(77, 1);
    wrMem(24'h9, 1, 1'b1);
    rdMem(24'h9, 1);
    chk(rbuf[0] == model[9], "R11 protect leaves memory writable", rbuf[0], model[9]);
    wpR = 1'b1;
    cmd1(8'h06);
    sel(); xfer(8'h01, d); xfer(8'h03, d); desel();
    rdsr(s);
    chk(s == 8'h00, "R11 status clear", s, 8'h00);

    // R10 hold in both modes
    holdRead(24'h2);
    mode3 = 1'b1;
    holdRead(24'hF);
    mode3 = 1'b0;

    // R2 activity with select high
    sckR = 1'b0; oeAny = 1'b0;
    for (int i = 7; i >= 0; i--) begin siR = OP_BIT(i); bitx(siR, r); end
    chk(!oeAny, "R2 no drive while deselected", oeAny, 0);
    rdsr(s);
    chk(s[1] == 1'b0, "R2 no latch set while deselected", s, 0);

    // R12 unknown opcode
    sel(); xfer(8'hAB, d); xfer(8'h06, d); xfer(8'h03, d); xfer(8'h00, d);
    chk(!oeAny, "R12 no drive after unknown opcode", oeAny, 0);
    desel();
    rdsr(s);
    chk(s == 8'h00, "R12 no latch change after unknown opcode", s, 8'h00);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  function automatic logic OP_BIT(input int i);
    logic [7:0] op;
    op = 8'h06;
    return op[i];
  endfunction

endmodule